// File: doc/BRIEF.md
# Constant On-Time Gate Sequencer

This block produces the two gate enables of a synchronous step-down converter regulated by a constant on-time loop. There is no free-running clock for switching. A new switching cycle starts when the feedback comparator reports that the output is below its reference. The high-side enable then stays on for a programmed number of system clock cycles. After that, the block enforces a minimum off interval before another cycle may start, and keeps a dead interval between the two gates in both directions. While the valley over-current comparator is asserted, no new cycle may begin.

The low-side enable follows one of two policies, chosen by the decoded mode input. In forced-continuous operation it is the complement of the high side, apart from dead intervals, and the zero-crossing comparator is ignored. In diode-emulation operation it turns off as soon as the inductor current reaches zero and stays off until the next pulse, so the switching rate falls at light load while the pulse width stays fixed. A third mode code shuts the stage down. Two override inputs from a fault supervisor act on the next clock edge: one forces both gates off, and one forces the low side on. The block also emits a one-cycle strobe at every high-side turn-on, which serves as the switching-cycle tick.

Top module: `cot_gate_sequencer`

## Requirements
- R1: While rst_n is low, hs_on_o, ls_on_o and cyc_tick_o are all 0.
- R2: In a running mode with no override, the high side rises on the edge where feedback is low, valley over-current is clear, the minimum off interval has elapsed, and the dead interval is complete. If the low side is on at that point, it is dropped first and the high side follows after the dead interval.
- R3: The two enables are never high together, and either one rises only after both have been low for DEAD_CYC consecutive clock periods.
- R4: An uninterrupted high-side pulse lasts exactly max(ton_i, 1) clock periods. ton_i is sampled on the edge where the pulse starts, and later changes apply only to the next pulse.
- R5: After the high side falls, it stays low for at least MIN_OFF_CYC clock periods.
- R6: While the high side is off and ocp_valley_i is 1, the high side does not rise on the next edge.
- R7: In diode-emulation mode (mode_i = 2'b10), the low side turns on after the dead interval that follows a high-side pulse. It turns off on the first edge at which zero_cross_i is 1, and stays off until the next high-side pulse has started.
- R8: In forced-continuous mode (mode_i = 2'b01), zero_cross_i has no effect. Whenever the high side is off and no start is pending, the low side is on once the dead interval is complete.
- R9: mode_i = 2'b00 (shutdown) and mode_i = 2'b11 (unused) drive both enables low on the next edge and start no cycles.
- R10: cyc_tick_o is 1 for exactly the first clock period of each high-side pulse, and 0 at all other times.
- R11: force_off_i = 1 drives both enables low on the next edge. It takes priority over every other input.
- R12: force_ls_i = 1 (without force_off_i) drops the high side on the next edge and turns the low side on once the dead interval is complete. The low side then stays on, whatever the feedback, zero-crossing or mode input (shutdown excepted).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 00 shutdown, 01 forced-continuous, 10 diode emulation, 11 treated as shutdown |
| fb_low_i | input | 1 | Feedback below reference |
| ocp_valley_i | input | 1 | Valley current above limit |
| zero_cross_i | input | 1 | Inductor current has reached zero |
| ton_i | input | TON_W | High-side on time in clock cycles |
| force_off_i | input | 1 | Supervisor override: both gates off |
| force_ls_i | input | 1 | Supervisor override: low side on |
| hs_on_o | output | 1 | High-side gate enable |
| ls_on_o | output | 1 | Low-side gate enable |
| cyc_tick_o | output | 1 | One-cycle strobe at each high-side turn-on |

## Verification
The main function is first tried with feedback held permanently low. This gives back-to-back cycles whose spacing is set only by the minimum off interval and the dead interval, which separates the on-time counter from the off-time counter. A run with the on-time value changing every cycle, including zero, shows whether the count is sampled only at pulse start. Sparse feedback requests combined with random zero-crossing pulses tell diode-emulation cutoff apart from forced-continuous complementing: the same zero-crossing pattern must cut the low side in one mode and leave it untouched in the other. Random valley-limit flags, mode changes and override bursts then test the priority order against a behavioural model compared on every clock.

// File: rtl/cot_gate_sequencer.sv
`timescale 1ns/1ps
module cot_gate_sequencer #(
  parameter int TON_W       = 10,
  parameter int DEAD_CYC    = 6,
  parameter int MIN_OFF_CYC = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             fb_low_i,
  input  logic             ocp_valley_i,
  input  logic             zero_cross_i,
  input  logic [TON_W-1:0] ton_i,
  input  logic             force_off_i,
  input  logic             force_ls_i,
  output logic             hs_on_o,
  output logic             ls_on_o,
  output logic             cyc_tick_o
);
  localparam int GAP_W = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
  localparam int OFF_W = (MIN_OFF_CYC > 1) ? $clog2(MIN_OFF_CYC) : 1;
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(DEAD_CYC - 1);
  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(MIN_OFF_CYC - 1);
  localparam logic [1:0] MODE_CCM = 2'b01;
  localparam logic [1:0] MODE_DEM = 2'b10;

  logic             hs_q, ls_q, tick_q, zc_q;
  logic             hs_n, ls_n;
  logic [TON_W-1:0] on_cnt;
  logic [GAP_W-1:0] gap_cnt;
  logic [OFF_W-1:0] off_cnt;

  wire running = (mode_i == MODE_CCM) || (mode_i == MODE_DEM);
  wire dem     = (mode_i == MODE_DEM);
  wire gap_ok  = !hs_q && !ls_q && (gap_cnt == GAP_LAST);
  wire off_ok  = (off_cnt == OFF_LAST);
  wire start   = fb_low_i && !ocp_valley_i && off_ok;
  wire ls_want = !dem || !(zc_q || zero_cross_i);
  wire hs_rise = hs_n && !hs_q;

  always_comb begin
    hs_n = 1'b0;
    ls_n = 1'b0;
    if (force_off_i || !running) begin
      hs_n = 1'b0;
      ls_n = 1'b0;
    end else if (force_ls_i) begin
      ls_n = ls_q || gap_ok;
    end else if (hs_q) begin
      hs_n = (on_cnt != '0);
    end else if (start) begin
      hs_n = gap_ok;
    end else begin
      ls_n = ls_want && (ls_q || gap_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q    <= 1'b0;
      ls_q    <= 1'b0;
      tick_q  <= 1'b0;
      zc_q    <= 1'b0;
      on_cnt  <= '0;
      gap_cnt <= GAP_LAST;
      off_cnt <= OFF_LAST;
    end else begin
      hs_q   <= hs_n;
      ls_q   <= ls_n;
      tick_q <= hs_rise;
      if (hs_rise)
        zc_q <= 1'b0;
      else if (dem && !hs_q && zero_cross_i)
        zc_q <= 1'b1;
      if (hs_rise)
        on_cnt <= (ton_i == '0) ? '0 : ton_i - 1'b1;
      else if (hs_q && on_cnt != '0)
        on_cnt <= on_cnt - 1'b1;
      if (hs_q || ls_q)
        gap_cnt <= '0;
      else if (gap_cnt != GAP_LAST)
        gap_cnt <= gap_cnt + 1'b1;
      if (hs_q)
        off_cnt <= '0;
      else if (off_cnt != OFF_LAST)
        off_cnt <= off_cnt + 1'b1;
    end
  end

  assign hs_on_o    = hs_q;
  assign ls_on_o    = ls_q;
  assign cyc_tick_o = tick_q;

  p_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on_o && ls_on_o));
  p_hs_after_ls_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on_o) |-> $past(!ls_on_o));
  p_ls_after_hs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_on_o) |-> $past(!hs_on_o));
  p_valley_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_on_o && ocp_valley_i) |=> !hs_on_o);
  p_shutdown_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> (!hs_on_o && !ls_on_o));
  p_force_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    force_off_i |=> (!hs_on_o && !ls_on_o));
  p_tick_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_tick_o |-> (hs_on_o && !$past(hs_on_o)));
  p_tick_cover_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on_o) |-> cyc_tick_o);
endmodule

// File: tb/cot_gate_sequencer_test.sv
`timescale 1ns/1ps
module cot_gate_sequencer_test;
  localparam int TON_W = 10;
  localparam int DEAD  = 6;
  localparam int MOFF  = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic fb = 1'b0, ocp = 1'b0, zc = 1'b0, f_off = 1'b0, f_ls = 1'b0;
  logic [TON_W-1:0] ton = 10'd20;
  logic hs, ls, tick;

  always #2.5 clk = ~clk;

  cot_gate_sequencer #(.TON_W(TON_W), .DEAD_CYC(DEAD), .MIN_OFF_CYC(MOFF)) uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .fb_low_i(fb), .ocp_valley_i(ocp),
    .zero_cross_i(zc), .ton_i(ton), .force_off_i(f_off), .force_ls_i(f_ls),
    .hs_on_o(hs), .ls_on_o(ls), .cyc_tick_o(tick));

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // behavioural reference
  int m_hs = 0, m_ls = 0, m_tick = 0, both_low = DEAD, hs_low = MOFF, rem = 0, zc_seen = 0;
  always @(posedge clk) begin
    int nh, nl, run, dem;
    if (!rst_n) begin
      m_hs = 0; m_ls = 0; m_tick = 0; both_low = DEAD; hs_low = MOFF; rem = 0; zc_seen = 0;
    end else begin
      both_low = (m_hs == 0 && m_ls == 0) ? (both_low < 1000 ? both_low + 1 : both_low) : 0;
      hs_low   = (m_hs == 0) ? (hs_low < 1000 ? hs_low + 1 : hs_low) : 0;
      run = (mode == 2'b01 || mode == 2'b10);
      dem = (mode == 2'b10);
      nh = 0; nl = 0;
      if (f_off || !run) begin
        nh = 0; nl = 0;
      end else if (f_ls) begin
        nl = (m_ls != 0 || both_low >= DEAD) ? 1 : 0;
      end else if (m_hs != 0) begin
        rem = rem - 1;
        nh = (rem > 0) ? 1 : 0;
      end else if (fb && !ocp && hs_low >= MOFF) begin
        nh = (m_ls == 0 && both_low >= DEAD) ? 1 : 0;
      end else begin
        if (!dem || !(zc_seen != 0 || zc))
          nl = (m_ls != 0 || both_low >= DEAD) ? 1 : 0;
      end
      m_tick = (nh != 0 && m_hs == 0) ? 1 : 0;
      if (m_tick != 0) begin
        zc_seen = 0;
        rem = (ton == 0) ? 1 : int'(ton);
      end else if (dem && m_hs == 0 && zc) zc_seen = 1;
      m_hs = nh; m_ls = nl;
    end
  end

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit rnd(int den);
    return ($urandom % den) == 0;
  endfunction

  bit prev_hs = 0, cut = 0, have_fall = 0;
  int hi_len = 0, lo_len = 0, rise_ton = 0;

  task automatic observe(string tag);
    int exp_w;
    check(hs == m_hs[0] && ls == m_ls[0] && tick == m_tick[0], tag, "hs/ls/tick",
          {hs, ls, tick}, {m_hs[0], m_ls[0], m_tick[0]});
    check(!(hs && ls), "R3", "both gates high", {hs, ls}, 0);
    if (hs && !prev_hs) begin
      if (have_fall) check(lo_len >= MOFF, "R5", "low interval", lo_len, MOFF);
      hi_len = 1; rise_ton = int'(ton); cut = 0;
    end else if (hs) hi_len++;
    else if (prev_hs) begin
      exp_w = (rise_ton == 0) ? 1 : rise_ton;
      if (!cut) check(hi_len == exp_w, "R4", "pulse width", hi_len, exp_w);
      lo_len = 1; have_fall = 1;
    end else lo_len++;
    prev_hs = hs;
  endtask

  task automatic phase(string tag, int n, int kind);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      observe(tag);
      case (kind)
        0: begin mode = 2'b01; fb = 1; ocp = 0; zc = 0; ton = 10'd20; end
        1: begin mode = 2'b01; fb = 1; ocp = 0; ton = TON_W'($urandom_range(0, 40)); end
        2: begin mode = 2'b01; fb = rnd(2); ocp = rnd(2); ton = 10'd15; end
        3: begin mode = 2'b10; fb = rnd(8); ocp = 0; zc = rnd(16); ton = 10'd12; end
        4: begin mode = 2'b01; fb = rnd(4); ocp = 0; zc = rnd(2); ton = 10'd25; end
        5: begin if (rnd(30)) mode = 2'($urandom_range(0, 3)); fb = rnd(3); zc = rnd(8); end
        6: begin if (rnd(60)) mode = (mode == 2'b01) ? 2'b10 : 2'b01;
                 fb = rnd(2); zc = rnd(10); if (rnd(10)) f_off = ~f_off; end
        7: begin mode = rnd(50) ? 2'b00 : 2'b10; fb = rnd(2); zc = rnd(6);
                 if (rnd(25)) f_ls = ~f_ls; f_off = rnd(40); end
        default: begin mode = 2'b01; fb = rnd(3); ocp = rnd(5); zc = 0; ton = 10'd9; end
      endcase
      if (hs && (f_off || f_ls || !(mode == 2'b01 || mode == 2'b10))) cut = 1;
    end
    f_off = 0; f_ls = 0; ocp = 0; zc = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    mode = 2'b01; fb = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!hs && !ls && !tick, "R1", "reset outputs", {hs, ls, tick}, 0);
    end
    rst_n = 1;
    phase("R2", 800, 0);
    phase("R5", 400, 0);
    phase("R4", 1200, 1);
    phase("R6", 1000, 2);
    phase("R7", 2000, 3);
    phase("R8", 1500, 4);
    phase("R9", 1500, 5);
    phase("R11", 1200, 6);
    phase("R12", 1500, 7);
    phase("R10", 800, 8);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule